// File: doc/BRIEF.md
# Isochronous Duplicate Channel Monitor

This block sits beside the receive side of a serial bus link and watches every stream packet that arrives. Software loads a 64-bit mask naming the channels on which this node is an active isochronous talker. Each received packet is presented as one valid strobe with its channel number and a flag that tells isochronous streams from asynchronous streams. A separate strobe marks the start of each isochronous cycle.

On each cycle the block keeps a record of the isochronous channels it has already heard. That record goes to the transmit scheduler as a per-channel inhibit vector, so the node does not talk on a channel that another node has already used in the current cycle. An isochronous packet that arrives on one of the node's own transmit channels raises a sticky duplicate interrupt and stores the channel number of the first offender. Asynchronous stream packets may share channels freely, so they are ignored for both purposes. A bus reset empties the per-cycle record but keeps the software mask.

Top module: `iso_dup_monitor`

## Requirements
- R1: After the synchronous reset, `tx_inhibit_o` is all zeros, `dup_irq_o` is 0, `dup_chan_o` is 0 and the transmit mask is all zeros.
- R2: An isochronous packet (`pkt_valid_i`=1, `pkt_is_iso_i`=1) on channel c sets bit c of `tx_inhibit_o` on the clock after the strobe. The bit stays set until a cycle start or a bus reset. This holds for every c from 0 to 63.
- R3: `cyc_start_i` clears every bit of `tx_inhibit_o` on the next clock. An isochronous packet on the same edge is still recorded, so only its bit is left set.
- R4: An asynchronous stream packet (`pkt_is_iso_i`=0) never changes `tx_inhibit_o`.
- R5: An isochronous packet whose channel bit is set in the transmit mask sets `dup_irq_o` on the clock after the strobe.
- R6: An asynchronous stream packet never sets `dup_irq_o`, even when its channel is in the mask.
- R7: `dup_irq_o` stays at 1 until `dup_clr_i` is pulsed. If a new duplicate arrives on the same edge as the clear, `dup_irq_o` stays at 1.
- R8: `dup_chan_o` takes the channel of a duplicate only when `dup_irq_o` is 0 or is being cleared on that edge. Later duplicates do not overwrite it, and a clear does not change it.
- R9: `bus_reset_i` clears `tx_inhibit_o` on the next clock and takes priority over a packet on the same edge. It leaves the transmit mask and `dup_irq_o` unchanged.
- R10: A pulse of `tx_mask_wr_i` loads `tx_mask_i` as the new mask. A packet on the same edge as the write is judged against the old mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Bus reset seen by the link; empties the per-cycle record |
| cyc_start_i | input | 1 | Start of a new isochronous cycle |
| pkt_valid_i | input | 1 | One received stream packet this clock |
| pkt_is_iso_i | input | 1 | 1 = isochronous stream, 0 = asynchronous stream |
| pkt_chan_i | input | 6 | Channel number of the received packet |
| tx_mask_wr_i | input | 1 | Software write strobe for the transmit mask |
| tx_mask_i | input | 64 | New value of the active transmit channel mask |
| dup_clr_i | input | 1 | Write-one pulse that clears the duplicate interrupt |
| tx_inhibit_o | output | 64 | Per-channel inhibit vector for the transmit scheduler |
| dup_irq_o | output | 1 | Sticky duplicate-channel interrupt |
| dup_chan_o | output | 6 | Channel of the first duplicate since the last clear |

## Verification
Every cycle, the assertions check four things: the registered recording of isochronous channels, the clearing on cycle start and bus reset, the stability of the inhibit vector while only asynchronous traffic arrives, and the stickiness of the interrupt and its captured channel. Some behaviour depends on the software mask, which is hidden inside the block. This covers mask-dependent detection, the old-mask-wins rule on a write edge, and the mask surviving a bus reset. Only the bench's scenarios can show these, because its reference model tracks the mask and compares all outputs on every clock.

// File: rtl/iso_dup_pkg.sv
package iso_dup_pkg;
  localparam int unsigned DEF_CHANNELS = 64;

  typedef enum logic {
    STREAM_ASYNC = 1'b0,
    STREAM_ISO   = 1'b1
  } stream_kind_e;
endpackage

// File: rtl/chan_heard_tracker.sv
module chan_heard_tracker #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_i,
  input  logic              cyc_start_i,
  input  logic              rec_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic [NUM_CH-1:0] heard_o
);
  // one flop per channel; a new packet beats the cycle-start clear
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst || bus_reset_i)
        heard_o[g] <= 1'b0;
      else if (rec_i && (chan_i == CH_W'(g)))
        heard_o[g] <= 1'b1;
      else if (cyc_start_i)
        heard_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/dup_detector.sv
module dup_detector #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              iso_pkt_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              clr_i,
  output logic              irq_o,
  output logic [CH_W-1:0]   chan_o
);
  logic [NUM_CH-1:0] tx_mask_q;
  logic              hit;
  logic              capture;

  assign hit     = iso_pkt_i && tx_mask_q[chan_i];
  assign capture = hit && (!irq_o || clr_i);

  always_ff @(posedge clk) begin
    if (rst)
      tx_mask_q <= '0;
    else if (mask_wr_i)
      tx_mask_q <= mask_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      chan_o <= '0;
    end else begin
      if (capture) begin
        irq_o  <= 1'b1;
        chan_o <= chan_i;
      end else if (clr_i) begin
        irq_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/iso_dup_monitor.sv
module iso_dup_monitor
  import iso_dup_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_CHANNELS,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset_i,
  input  logic              cyc_start_i,
  input  logic              pkt_valid_i,
  input  logic              pkt_is_iso_i,
  input  logic [CH_W-1:0]   pkt_chan_i,
  input  logic              tx_mask_wr_i,
  input  logic [NUM_CH-1:0] tx_mask_i,
  input  logic              dup_clr_i,
  output logic [NUM_CH-1:0] tx_inhibit_o,
  output logic              dup_irq_o,
  output logic [CH_W-1:0]   dup_chan_o
);
  stream_kind_e kind;
  logic         iso_pkt;

  assign kind    = stream_kind_e'(pkt_is_iso_i);
  assign iso_pkt = pkt_valid_i && (kind == STREAM_ISO);

  chan_heard_tracker #(.NUM_CH(NUM_CH)) heard_i (
    .clk        (clk),
    .rst        (rst),
    .bus_reset_i(bus_reset_i),
    .cyc_start_i(cyc_start_i),
    .rec_i      (iso_pkt),
    .chan_i     (pkt_chan_i),
    .heard_o    (tx_inhibit_o)
  );

  dup_detector #(.NUM_CH(NUM_CH)) det_i (
    .clk      (clk),
    .rst      (rst),
    .mask_wr_i(tx_mask_wr_i),
    .mask_i   (tx_mask_i),
    .iso_pkt_i(iso_pkt),
    .chan_i   (pkt_chan_i),
    .clr_i    (dup_clr_i),
    .irq_o    (dup_irq_o),
    .chan_o   (dup_chan_o)
  );
endmodule

// File: rtl/iso_dup_monitor_chk.sv
module iso_dup_monitor_chk #(
  parameter int unsigned NUM_CH = 64,
  localparam int unsigned CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_reset_i,
  input logic              cyc_start_i,
  input logic              pkt_valid_i,
  input logic              pkt_is_iso_i,
  input logic [CH_W-1:0]   pkt_chan_i,
  input logic              dup_clr_i,
  input logic [NUM_CH-1:0] tx_inhibit_o,
  input logic              dup_irq_o,
  input logic [CH_W-1:0]   dup_chan_o
);
  assert_iso_recorded_R2: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid_i && pkt_is_iso_i && !bus_reset_i) |=> tx_inhibit_o[$past(pkt_chan_i)]);

  assert_cycle_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (cyc_start_i && !(pkt_valid_i && pkt_is_iso_i)) |=> (tx_inhibit_o == '0));

  assert_async_no_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
    (!(pkt_valid_i && pkt_is_iso_i) && !cyc_start_i && !bus_reset_i) |=> $stable(tx_inhibit_o));

  assert_async_no_irq_R6: assert property (@(posedge clk) disable iff (rst)
    (!dup_irq_o && !(pkt_valid_i && pkt_is_iso_i)) |=> !dup_irq_o);

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (dup_irq_o && !dup_clr_i) |=> dup_irq_o);

  assert_first_chan_held_R8: assert property (@(posedge clk) disable iff (rst)
    (dup_irq_o && !dup_clr_i) |=> $stable(dup_chan_o));

  assert_bus_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    bus_reset_i |=> (tx_inhibit_o == '0));
endmodule

bind iso_dup_monitor iso_dup_monitor_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .bus_reset_i (bus_reset_i),
  .cyc_start_i (cyc_start_i),
  .pkt_valid_i (pkt_valid_i),
  .pkt_is_iso_i(pkt_is_iso_i),
  .pkt_chan_i  (pkt_chan_i),
  .dup_clr_i   (dup_clr_i),
  .tx_inhibit_o(tx_inhibit_o),
  .dup_irq_o   (dup_irq_o),
  .dup_chan_o  (dup_chan_o)
);

// File: tb/iso_dup_monitor_tb_top.sv
module iso_dup_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bus_reset_i = 1'b0;
  logic            cyc_start_i = 1'b0;
  logic            pkt_valid_i = 1'b0;
  logic            pkt_is_iso_i = 1'b0;
  logic [5:0]      pkt_chan_i = '0;
  logic            tx_mask_wr_i = 1'b0;
  logic [NCH-1:0]  tx_mask_i = '0;
  logic            dup_clr_i = 1'b0;
  logic [NCH-1:0]  tx_inhibit_o;
  logic            dup_irq_o;
  logic [5:0]      dup_chan_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_heard [NCH];
  bit          m_mask  [NCH];
  bit          m_irq;
  int          m_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_dup_monitor dut_i (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .cyc_start_i(cyc_start_i),
    .pkt_valid_i(pkt_valid_i), .pkt_is_iso_i(pkt_is_iso_i), .pkt_chan_i(pkt_chan_i),
    .tx_mask_wr_i(tx_mask_wr_i), .tx_mask_i(tx_mask_i), .dup_clr_i(dup_clr_i),
    .tx_inhibit_o(tx_inhibit_o), .dup_irq_o(dup_irq_o), .dup_chan_o(dup_chan_o)
  );

  function automatic logic [NCH-1:0] heard_vec();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = m_heard[i];
    return v;
  endfunction

  task automatic model_edge();
    int  c;
    bit  hit;
    c = int'(pkt_chan_i);
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin m_heard[i] = 0; m_mask[i] = 0; end
      m_irq = 0; m_chan = 0;
      return;
    end
    hit = pkt_valid_i && pkt_is_iso_i && m_mask[c];
    if (hit && (!m_irq || dup_clr_i)) begin m_irq = 1; m_chan = c; end
    else if (dup_clr_i) m_irq = 0;
    if (bus_reset_i) begin
      for (int i = 0; i < NCH; i++) m_heard[i] = 0;
    end else begin
      if (cyc_start_i) for (int i = 0; i < NCH; i++) m_heard[i] = 0;
      if (pkt_valid_i && pkt_is_iso_i) m_heard[c] = 1;
    end
    if (tx_mask_wr_i) for (int i = 0; i < NCH; i++) m_mask[i] = tx_mask_i[i];
  endtask

  task automatic check(string req, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: inputs already driven at negedge; model at posedge; compare at next negedge
  task automatic step(string req);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check({req, " inhibit"}, tx_inhibit_o, heard_vec());
    check({req, " irq"}, NCH'(dup_irq_o), NCH'(m_irq));
    check({req, " chan"}, NCH'(dup_chan_o), NCH'(m_chan));
    pkt_valid_i = 0; cyc_start_i = 0; bus_reset_i = 0;
    tx_mask_wr_i = 0; dup_clr_i = 0; rst = 0;
  endtask

  task automatic pkt(bit iso, int ch);
    pkt_valid_i = 1; pkt_is_iso_i = iso; pkt_chan_i = 6'(ch);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; step("R1 reset");
    step("R1 idle");
    // R2: edge channels and a middle one
    pkt(1, 0);  step("R2 ch0");
    pkt(1, 63); step("R2 ch63");
    pkt(1, 17); step("R2 ch17");
    step("R2 hold");
    // R4: async leaves record alone
    pkt(0, 40); step("R4 async");
    pkt(0, 17); step("R4 async repeat");
    // R3: clear with and without packet on same edge
    cyc_start_i = 1; pkt(1, 5); step("R3 start+pkt");
    cyc_start_i = 1; step("R3 start");
    // R10: mask write, packet same edge uses old mask
    tx_mask_wr_i = 1; tx_mask_i = 64'h8000_0000_0000_0108; pkt(1, 3); step("R10 same edge");
    if (dup_irq_o !== 1'b0) begin tests++; fails++; $display("FAIL R10: actual 1 expected 0"); end
    else tests++;
    // R6: async on masked channel
    pkt(0, 3); step("R6 async masked");
    // R5: iso on masked channel
    pkt(1, 8); step("R5 dup ch8");
    // R8: later duplicate does not overwrite
    pkt(1, 63); step("R8 second dup");
    // R7: sticky then clear
    step("R7 sticky");
    dup_clr_i = 1; step("R7 clear");
    // R7/R8: clear with new dup same edge
    pkt(1, 3); step("R7 dup");
    dup_clr_i = 1; pkt(1, 63); step("R7 clr+dup");
    // R9: bus reset beats packet, mask and irq kept
    bus_reset_i = 1; pkt(1, 20); step("R9 bus reset");
    dup_clr_i = 1; step("R9 clear");
    pkt(1, 8); step("R9 mask kept");
    // mixed traffic sweep
    for (int k = 0; k < 200; k++) begin
      pkt((k % 3) != 0, (k * 7) % 64);
      cyc_start_i = (k % 11) == 0;
      dup_clr_i = (k % 13) == 0;
      bus_reset_i = (k % 37) == 5;
      tx_mask_wr_i = (k % 50) == 25;
      tx_mask_i = {32'(k * 977), 32'(k * 131)};
      step("R2 sweep");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule